// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block produces the column address order for a single read or write burst on a double-data-rate memory. A column command (`cmd_start`) loads a starting column together with two mode fields: a 3-bit length code and a 1-bit order select. From the next clock on, the block issues two column addresses per clock, one for each clock edge, until the burst is complete.

The block reports where the burst stands through two outputs. `beat_idx` gives the index of the first beat of the current pair. `last_pair` marks the pair that holds the final beat.

A burst ends early in two ways:
- A burst-stop input (`cmd_stop`) cuts it short.
- A new column command replaces it at once. Because of this, column commands may arrive on consecutive clocks.

An undefined length code does not start a burst. It pulses an error flag instead.

Top module: `burst_col_seq`

## Requirements
- R1: While reset is asserted, and after it is released until the first valid command, `busy`, `last_pair` and `len_err` are low, and `col_even`, `col_odd` and `beat_idx` are zero. Whenever `busy` is low, `col_even`, `col_odd` and `beat_idx` read zero.
- R2: The length code `len_code` selects a burst of 2^len_code beats, valid only for codes 1, 2, 3 and 4 (2, 4, 8 and 16 beats). A valid start makes `busy` high from the clock after `cmd_start` for exactly len/2 clocks.
- R3: With `order_sel` = 0 (sequential), beat k uses column low bits (start + k) mod len, so the low bits wrap inside the len-aligned block. A start of 5 with 8 beats yields 5,6,7,0,1,2,3,4.
- R4: With `order_sel` = 1 (interleaved), beat k uses column low bits start XOR k. A start of 5 with 8 beats yields 5,4,7,6,1,0,3,2.
- R5: Column bits at and above bit log2(len) hold the start column's value for the whole burst.
- R6: Each busy clock carries two beats. `col_even` is beat `beat_idx` and `col_odd` is beat `beat_idx`+1. `beat_idx` starts at 0 and rises by 2 each clock.
- R7: `last_pair` is high only on the clock whose pair contains beat len-1. Without a new start in that clock, `busy` is low on the next clock.
- R8: A valid `cmd_start` while busy, including on the last pair, restarts on the next clock with the new start column at beat 0, and `busy` stays high with no gap.
- R9: `cmd_stop` while busy makes `busy` low on the next clock. When `cmd_start` with a valid code arrives in the same clock, the start wins and a new burst begins.
- R10: A `cmd_start` with an undefined length code (0, 5, 6 or 7) raises `len_err` for one clock on the next clock and starts nothing. A burst already running continues unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_start | input | 1 | Column command: start a new burst |
| start_col | input | COL_W | Starting column address for the burst |
| len_code | input | 3 | Burst length code (1..4 valid) |
| order_sel | input | 1 | 0 sequential, 1 interleaved |
| cmd_stop | input | 1 | Burst stop |
| busy | output | 1 | A burst is being emitted this clock |
| col_even | output | COL_W | Column of beat `beat_idx` (rising-edge beat) |
| col_odd | output | COL_W | Column of beat `beat_idx`+1 (falling-edge beat) |
| beat_idx | output | log2(BL_MAX) | Index of the first beat of this clock's pair |
| last_pair | output | 1 | This pair contains the final beat |
| len_err | output | 1 | Previous clock's start carried an undefined length code |

## Verification
Three functions can land in the same clock:
- A burst stop and a valid new column command. The bench issues both mid-burst and expects the new burst's beat 0 to appear on the next clock.
- A new command and the final pair of the running burst. The bench issues the command on the last pair and expects `busy` to stay high with the new start column at beat 0, with no idle clock between the bursts.
- A start with an undefined length code and a running burst. The bench issues it mid-burst and checks two things on the next clock: `len_err` is high, and the running burst has advanced its column pair exactly as if nothing had happened.

// File: rtl/bcs_pkg.sv
package bcs_pkg;
    typedef enum logic {
        ORD_SEQ   = 1'b0,
        ORD_INTLV = 1'b1
    } order_e;
endpackage

// File: rtl/bcs_len_dec.sv
module bcs_len_dec #(
    parameter int BL_MAX = 16,
    localparam int LOG_MAX = $clog2(BL_MAX),
    localparam int LEN_W = LOG_MAX + 1
) (
    input  logic [2:0]       code,
    output logic [LEN_W-1:0] len,
    output logic             ok
);
    always_comb begin
        ok  = (code != 3'd0) && (int'(code) <= LOG_MAX);
        len = ok ? LEN_W'(1) << code : '0;
    end
endmodule

// File: rtl/bcs_lane.sv
module bcs_lane
    import bcs_pkg::*;
#(
    parameter int COL_W = 10,
    parameter int LEN_W = 5
) (
    input  logic [COL_W-1:0] base,
    input  logic [LEN_W-1:0] len,
    input  logic [LEN_W-1:0] beat,
    input  order_e           order,
    output logic [COL_W-1:0] col
);
    logic [COL_W-1:0] mask;
    logic [COL_W-1:0] step;
    logic [COL_W-1:0] wrap_col;
    logic [COL_W-1:0] xor_col;

    always_comb begin
        mask     = COL_W'(len) - COL_W'(1);
        step     = COL_W'(beat);
        wrap_col = (base & ~mask) | ((base + step) & mask);
        xor_col  = base ^ step;
        col      = (order == ORD_INTLV) ? xor_col : wrap_col;
    end
endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq
    import bcs_pkg::*;
#(
    parameter int COL_W = 10,
    parameter int BL_MAX = 16,
    localparam int IDX_W = $clog2(BL_MAX),
    localparam int LEN_W = IDX_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_start,
    input  logic [COL_W-1:0] start_col,
    input  logic [2:0]       len_code,
    input  logic             order_sel,
    input  logic             cmd_stop,
    output logic             busy,
    output logic [COL_W-1:0] col_even,
    output logic [COL_W-1:0] col_odd,
    output logic [IDX_W-1:0] beat_idx,
    output logic             last_pair,
    output logic             len_err
);
    typedef struct packed {
        logic             run;
        logic [COL_W-1:0] base;
        logic [LEN_W-1:0] len;
        logic [LEN_W-1:0] beat;
        order_e           order;
        logic             err;
    } state_t;

    state_t st_d, st_q;

    logic [LEN_W-1:0] dec_len;
    logic             dec_ok;
    logic             at_end;
    logic [COL_W-1:0] lane_col [2];

    bcs_len_dec #(.BL_MAX(BL_MAX)) u_dec (
        .code (len_code),
        .len  (dec_len),
        .ok   (dec_ok)
    );

    for (genvar g = 0; g < 2; g++) begin : g_lane
        bcs_lane #(.COL_W(COL_W), .LEN_W(LEN_W)) u_lane (
            .base  (st_q.base),
            .len   (st_q.len),
            .beat  (st_q.beat + LEN_W'(g)),
            .order (st_q.order),
            .col   (lane_col[g])
        );
    end

    assign at_end = st_q.run && ((st_q.beat + LEN_W'(2)) == st_q.len);

    always_comb begin
        st_d     = st_q;
        st_d.err = cmd_start && !dec_ok;
        if (cmd_start && dec_ok) begin
            st_d.run   = 1'b1;
            st_d.base  = start_col;
            st_d.len   = dec_len;
            st_d.beat  = '0;
            st_d.order = order_e'(order_sel);
        end else if (cmd_stop || at_end) begin
            st_d.run  = 1'b0;
            st_d.beat = '0;
        end else if (st_q.run) begin
            st_d.beat = st_q.beat + LEN_W'(2);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{run: 1'b0, base: '0, len: '0, beat: '0,
                      order: ORD_SEQ, err: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign busy      = st_q.run;
    assign col_even  = st_q.run ? lane_col[0] : '0;
    assign col_odd   = st_q.run ? lane_col[1] : '0;
    assign beat_idx  = st_q.run ? st_q.beat[IDX_W-1:0] : '0;
    assign last_pair = at_end;
    assign len_err   = st_q.err;
endmodule

// File: rtl/burst_col_seq_chk.sv
module burst_col_seq_chk #(
    parameter int COL_W = 10,
    parameter int BL_MAX = 16,
    localparam int IDX_W = $clog2(BL_MAX)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cmd_start,
    input logic [2:0]       len_code,
    input logic             cmd_stop,
    input logic             busy,
    input logic [COL_W-1:0] col_even,
    input logic [IDX_W-1:0] beat_idx,
    input logic             last_pair,
    input logic             len_err
);
    logic code_good;
    assign code_good = (len_code >= 3'd1) && (int'(len_code) <= IDX_W);

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!last_pair && beat_idx == '0 && col_even == '0)); // R1
    AST_START_BEAT0: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_start && code_good) |=> (busy && beat_idx == '0)); // R8
    AST_STEP_TWO: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !cmd_start && !cmd_stop && !last_pair) |=>
        (busy && beat_idx == $past(beat_idx) + IDX_W'(2))); // R6
    AST_UPPER_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !cmd_start && !cmd_stop && !last_pair) |=>
        (col_even[COL_W-1:IDX_W] == $past(col_even[COL_W-1:IDX_W]))); // R5
    AST_LAST_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (last_pair && !cmd_start) |=> !busy); // R7
    AST_STOP_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_stop && !cmd_start) |=> !busy); // R9
    AST_BAD_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_start && !code_good) |=> len_err); // R10
    AST_BAD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_start && !code_good && !busy) |=> !busy); // R10
endmodule

bind burst_col_seq burst_col_seq_chk #(.COL_W(COL_W), .BL_MAX(BL_MAX)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_start (cmd_start),
    .len_code  (len_code),
    .cmd_stop  (cmd_stop),
    .busy      (busy),
    .col_even  (col_even),
    .beat_idx  (beat_idx),
    .last_pair (last_pair),
    .len_err   (len_err)
);

// File: tb/tb_burst_col_seq.sv
module tb_burst_col_seq;
    localparam int COL_W = 10;
    localparam int BL_MAX = 16;
    localparam int IDX_W = 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cmd_start = 1'b0;
    logic [COL_W-1:0] start_col = '0;
    logic [2:0]       len_code = 3'd0;
    logic             order_sel = 1'b0;
    logic             cmd_stop = 1'b0;
    logic             busy;
    logic [COL_W-1:0] col_even;
    logic [COL_W-1:0] col_odd;
    logic [IDX_W-1:0] beat_idx;
    logic             last_pair;
    logic             len_err;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    burst_col_seq #(.COL_W(COL_W), .BL_MAX(BL_MAX)) dut (
        .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .start_col(start_col),
        .len_code(len_code), .order_sel(order_sel), .cmd_stop(cmd_stop),
        .busy(busy), .col_even(col_even), .col_odd(col_odd),
        .beat_idx(beat_idx), .last_pair(last_pair), .len_err(len_err)
    );

    task automatic chk(input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int exp_col(input int b, input int k, input int len, input bit il);
        int lo;
        if (il) return b ^ k;
        lo = b % len;
        return b - lo + ((lo + k) % len);
    endfunction

    task automatic issue(input int col, input int code, input bit il);
        start_col = COL_W'(col);
        len_code  = 3'(code);
        order_sel = il;
        cmd_start = 1'b1;
        @(negedge clk);
        cmd_start = 1'b0;
    endtask

    task automatic check_pair(input string req, input int b, input int i,
                              input int len, input bit il);
        chk(req, "busy", int'(busy), 1);
        chk(req, "col_even", int'(col_even), exp_col(b, 2 * i, len, il));
        chk(req, "col_odd", int'(col_odd), exp_col(b, 2 * i + 1, len, il));
        chk("R6", "beat_idx", int'(beat_idx), 2 * i);
        chk("R7", "last_pair", int'(last_pair), int'(i == len / 2 - 1));
    endtask

    task automatic full_burst(input string req, input int b, input int code, input bit il);
        int len = 1 << code;
        issue(b, code, il);
        for (int i = 0; i < len / 2; i++) begin
            check_pair(req, b, i, len, il);
            @(negedge clk);
        end
        chk("R2", "busy after burst", int'(busy), 0);
        chk("R1", "idle col_even", int'(col_even), 0);
    endtask

    task automatic t_reset;
        chk("R1", "busy", int'(busy), 0);
        chk("R1", "last_pair", int'(last_pair), 0);
        chk("R1", "len_err", int'(len_err), 0);
        chk("R1", "col_odd", int'(col_odd), 0);
        chk("R1", "beat_idx", int'(beat_idx), 0);
    endtask

    task automatic t_literal_orders;
        int seq_v[8] = '{5, 6, 7, 0, 1, 2, 3, 4};
        int il_v[8]  = '{5, 4, 7, 6, 1, 0, 3, 2};
        issue(10'h0C5, 3, 1'b0);
        for (int i = 0; i < 4; i++) begin
            chk("R3", "seq even", int'(col_even), 10'h0C0 | seq_v[2 * i]);
            chk("R3", "seq odd", int'(col_odd), 10'h0C0 | seq_v[2 * i + 1]);
            chk("R5", "upper bits", int'(col_even[COL_W-1:3]), 10'h0C0 >> 3);
            @(negedge clk);
        end
        issue(10'h2A5, 3, 1'b1);
        for (int i = 0; i < 4; i++) begin
            chk("R4", "intlv even", int'(col_even), 10'h2A0 | il_v[2 * i]);
            chk("R4", "intlv odd", int'(col_odd), 10'h2A0 | il_v[2 * i + 1]);
            @(negedge clk);
        end
    endtask

    task automatic t_all_lengths;
        for (int code = 1; code <= 4; code++) begin
            full_burst("R3", 10'h3B7, code, 1'b0);
            full_burst("R4", 10'h14D, code, 1'b1);
        end
        full_burst("R5", 10'h3FF, 4, 1'b0);
    endtask

    task automatic t_bad_codes;
        int bad[4] = '{0, 5, 6, 7};
        for (int j = 0; j < 4; j++) begin
            issue(10'h011, bad[j], 1'b0);
            chk("R10", "len_err idle", int'(len_err), 1);
            chk("R10", "no burst", int'(busy), 0);
            @(negedge clk);
            chk("R10", "len_err one clock", int'(len_err), 0);
        end
    endtask

    task automatic t_stop;
        issue(10'h066, 3, 1'b0);
        check_pair("R9", 10'h066, 0, 8, 1'b0);
        cmd_stop = 1'b1;
        @(negedge clk);
        cmd_stop = 1'b0;
        chk("R9", "busy after stop", int'(busy), 0);
        chk("R9", "last after stop", int'(last_pair), 0);
    endtask

    task automatic t_restart;
        issue(10'h10A, 4, 1'b0);
        @(negedge clk);
        check_pair("R8", 10'h10A, 1, 16, 1'b0);
        issue(10'h2F3, 2, 1'b1);
        check_pair("R8", 10'h2F3, 0, 4, 1'b1);
        @(negedge clk);
        check_pair("R8", 10'h2F3, 1, 4, 1'b1);
        @(negedge clk);
        chk("R8", "busy after restarted burst", int'(busy), 0);
    endtask

    task automatic t_back_to_back;
        issue(10'h04E, 2, 1'b0);
        @(negedge clk);
        chk("R8", "last of first", int'(last_pair), 1);
        issue(10'h1D9, 1, 1'b1);
        check_pair("R8", 10'h1D9, 0, 2, 1'b1);
        @(negedge clk);
        chk("R7", "busy after len2", int'(busy), 0);
    endtask

    task automatic t_stop_and_start;
        issue(10'h0F0, 3, 1'b1);
        cmd_stop = 1'b1;
        issue(10'h233, 3, 1'b0);
        cmd_stop = 1'b0;
        check_pair("R9", 10'h233, 0, 8, 1'b0);
        cmd_stop = 1'b1;
        @(negedge clk);
        cmd_stop = 1'b0;
        chk("R9", "stopped", int'(busy), 0);
    endtask

    task automatic t_bad_in_burst;
        issue(10'h155, 3, 1'b1);
        issue(10'h000, 6, 1'b0);
        chk("R10", "len_err in burst", int'(len_err), 1);
        check_pair("R10", 10'h155, 1, 8, 1'b1);
        @(negedge clk);
        chk("R10", "len_err cleared", int'(len_err), 0);
        check_pair("R10", 10'h155, 2, 8, 1'b1);
        @(negedge clk);
        @(negedge clk);
        chk("R10", "burst finished", int'(busy), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_literal_orders();
        t_all_lengths();
        t_bad_codes();
        t_stop();
        t_restart();
        t_back_to_back();
        t_stop_and_start();
        t_bad_in_burst();
        done = 1'b1;
    end

    initial begin
        for (int n = 0; n < 20000 && !done; n++) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=running expected=done");
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule